// File: doc/BRIEF.md
# Shared Prescaler Timer Clock Divider

This block produces the count-enable strobes for five down-counting timer channels, all running from one fixed 24 MHz reference clock. Two 8-bit prescalers divide the reference first. The low prescaler feeds channels 0 and 1, and the high prescaler feeds channels 2, 3 and 4. Each channel then applies its own power-of-two post-divider, chosen by a 4-bit select field. A channel therefore gets a one-cycle tick every (P+1)·2^D reference cycles. P is the value of the prescaler the channel uses, and D is the channel's select field.

Two configuration words hold the settings. Software writes them through a single write port, selected by `cfg_wr_sel`, and both words are always visible on readback outputs. Any configuration write restarts every prescaler and every post-divider. The new setting then takes effect at once on all five channels, and no channel finishes a period that was only partly elapsed under the old setting. The down-counters, reload logic, interrupts and waveform generation sit downstream and consume the tick strobes.

Top module: `tmr_clkdiv`

## Requirements
- R1: A synchronous reset sets the prescaler word to 0x0101 and the divider-select word to 0x00000, and holds every tick low. After reset is released, each channel ticks every 2 cycles. The first tick appears in the second cycle after the last reset edge.
- R2: A write with `cfg_wr_en`=1 and `cfg_wr_sel`=0 stores `cfg_wr_data[15:0]` into the prescaler word. With `cfg_wr_sel`=1 it stores `cfg_wr_data[19:0]` into the divider-select word. The stored value is visible on the readback port in the cycle after the write edge.
- R3: Channels 0 and 1 take P from prescaler word bits [7:0]. Channels 2, 3 and 4 take P from bits [15:8].
- R4: Channel n takes D from divider-select word bits [4n+3:4n].
- R5: Each tick is high for exactly one cycle, and it repeats with a period of (P+1)·2^D cycles.
- R6: A write to either word restarts all channels. Counting the cycle after the write edge as cycle 0, a channel with period N ticks in cycle N-1 and every N cycles after that.
- R7: While `cfg_wr_en` is 0, neither configuration word changes, whatever `cfg_wr_sel` and `cfg_wr_data` carry.
- R8: With P=0 and D=0, the channel ticks in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 1 | 0 selects the prescaler word, 1 selects the divider-select word |
| cfg_wr_data | input | 20 | Write data |
| presc_word | output | 16 | Readback of the prescaler word |
| divsel_word | output | 20 | Readback of the divider-select word |
| tick | output | 5 | One-cycle count-enable strobe per channel |

## Verification
The bench goes after the uneven sharing of the two prescalers. A design that wires channel 2 to the low prescaler, or channel 1 to the high one, shows up as a wrong period once the two prescaler values differ. It loads a distinct select value into every field, so a field read from the wrong nibble or shifted by one bit gives a wrong period on some channel. It also checks the phase of the first tick after reset and after writes made in the middle of a period. A design that keeps its old count through a write ticks early or late compared with the restarted schedule. Finally, it covers P=0 with D=0, where an off-by-one reload would skip cycles, and writes that carry data while the enable is low.

// File: rtl/tmr_clkdiv_pkg.sv
package tmr_clkdiv_pkg;

    // Number of shared prescalers; channel grouping depends on it.
    localparam int NUM_PRE = 2;

    typedef enum logic {
        CFG_PRESC  = 1'b0,
        CFG_DIVSEL = 1'b1
    } cfg_sel_e;

    // Which prescaler drives a given channel.
    function automatic int grp_of(input int ch, input int split);
        return (ch < split) ? 0 : 1;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tmr_clkdiv_cfg.sv
module tmr_clkdiv_cfg
    import tmr_clkdiv_pkg::*;
#(
    parameter int PRE_W  = 8,
    parameter int NUM_CH = 5,
    parameter int SEL_W  = 4,
    parameter int WR_W   = 20
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  cfg_sel_e                    wr_sel,
    input  logic [WR_W-1:0]             wr_data,
    output logic [NUM_PRE*PRE_W-1:0]    presc_q,
    output logic [NUM_PRE*PRE_W-1:0]    presc_nxt,
    output logic [NUM_CH*SEL_W-1:0]     div_q,
    output logic                        restart
);
    localparam int PW = NUM_PRE * PRE_W;
    localparam int DW = NUM_CH * SEL_W;
    localparam logic [PW-1:0] PRESC_RST = {NUM_PRE{PRE_W'(1)}};

    logic [DW-1:0] div_nxt;

    always_comb begin
        presc_nxt = presc_q;
        div_nxt   = div_q;
        if (rst) begin
            presc_nxt = PRESC_RST;
            div_nxt   = '0;
        end else if (wr_en) begin
            if (wr_sel == CFG_PRESC) presc_nxt = wr_data[PW-1:0];
            else                     div_nxt   = wr_data[DW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        presc_q <= presc_nxt;
        div_q   <= div_nxt;
    end

    assign restart = rst | wr_en;

    // R1
    rst_val_chk: assert property (@(posedge clk)
        rst |=> (presc_q == PRESC_RST) && (div_q == '0));

    // R7
    hold_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(presc_q) && $stable(div_q));

endmodule

// File: rtl/tmr_clkdiv_pre.sv
module tmr_clkdiv_pre #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [PRE_W-1:0] start_val,
    input  logic [PRE_W-1:0] reload_val,
    output logic             stb
);
    logic [PRE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (restart)           cnt_q <= start_val;
        else if (cnt_q == '0)  cnt_q <= reload_val;
        else                   cnt_q <= cnt_q - 1'b1;
    end

    assign stb = (cnt_q == '0);

    // R5
    pre_gap_chk: assert property (@(posedge clk) disable iff (rst)
        stb && !restart && (reload_val != '0) |=> !stb);

endmodule

// File: rtl/tmr_clkdiv_post.sv
module tmr_clkdiv_post #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             stb_in,
    input  logic [SEL_W-1:0] sel,
    output logic             tick_out
);
    localparam int CNT_W = (2 ** SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;

    assign mask = ~({CNT_W{1'b1}} << sel);

    always_ff @(posedge clk) begin
        if (restart)     cnt_q <= '0;
        else if (stb_in) cnt_q <= cnt_q + 1'b1;
    end

    assign tick_out = stb_in && ((cnt_q & mask) == mask);

    // R5
    one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        tick_out && (sel != '0) && !restart |=> !tick_out);

endmodule

// File: rtl/tmr_clkdiv.sv
module tmr_clkdiv
    import tmr_clkdiv_pkg::*;
#(
    parameter int NUM_CH   = 5,
    parameter int PRE_W    = 8,
    parameter int SEL_W    = 4,
    parameter int SPLIT_CH = 2
) (
    input  logic                                              clk,
    input  logic                                              rst,
    input  logic                                              cfg_wr_en,
    input  logic                                              cfg_wr_sel,
    input  logic [max2(NUM_PRE*PRE_W, NUM_CH*SEL_W)-1:0]      cfg_wr_data,
    output logic [NUM_PRE*PRE_W-1:0]                          presc_word,
    output logic [NUM_CH*SEL_W-1:0]                           divsel_word,
    output logic [NUM_CH-1:0]                                 tick
);
    localparam int WR_W = max2(NUM_PRE * PRE_W, NUM_CH * SEL_W);

    logic [NUM_PRE*PRE_W-1:0] presc_nxt;
    logic                     restart;
    logic [NUM_PRE-1:0]       pre_stb;
    cfg_sel_e                 sel_e;

    assign sel_e = cfg_sel_e'(cfg_wr_sel);

    tmr_clkdiv_cfg #(
        .PRE_W(PRE_W), .NUM_CH(NUM_CH), .SEL_W(SEL_W), .WR_W(WR_W)
    ) u_cfg (
        .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_sel(sel_e),
        .wr_data(cfg_wr_data), .presc_q(presc_word), .presc_nxt(presc_nxt),
        .div_q(divsel_word), .restart(restart)
    );

    for (genvar g = 0; g < NUM_PRE; g++) begin : g_pre
        tmr_clkdiv_pre #(.PRE_W(PRE_W)) u_pre (
            .clk(clk), .rst(rst), .restart(restart),
            .start_val(presc_nxt[g*PRE_W +: PRE_W]),
            .reload_val(presc_word[g*PRE_W +: PRE_W]),
            .stb(pre_stb[g])
        );
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int GRP = grp_of(i, SPLIT_CH);

        tmr_clkdiv_post #(.SEL_W(SEL_W)) u_post (
            .clk(clk), .rst(rst), .restart(restart),
            .stb_in(pre_stb[GRP]),
            .sel(divsel_word[i*SEL_W +: SEL_W]),
            .tick_out(tick[i])
        );

        // R3
        grp_src_chk: assert property (@(posedge clk) disable iff (rst)
            tick[i] |-> pre_stb[GRP]);
    end

endmodule

// File: tb/tmr_clkdiv_bench.sv
module tmr_clkdiv_bench;
    localparam int NCH = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_wr_sel = 1'b0;
    logic [19:0] cfg_wr_data = '0;
    logic [15:0] presc_word;
    logic [19:0] divsel_word;
    logic [4:0]  tick;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string phase = "R1";

    // Behavioural model state
    int m_pw = 'h0101;
    int m_dw = 0;
    int m_since = 0;

    always #4 clk = ~clk;

    tmr_clkdiv u_tmr_clkdiv (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .presc_word(presc_word),
        .divsel_word(divsel_word), .tick(tick)
    );

    function automatic int period_of(int ch, int pw, int dw);
        int p = (ch < 2) ? (pw & 'hFF) : ((pw >> 8) & 'hFF);
        int d = (dw >> (4 * ch)) & 'hF;
        return (p + 1) << d;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pw = 'h0101; m_dw = 0; m_since = 0;
        end else if (cfg_wr_en) begin
            if (cfg_wr_sel) m_dw = int'(cfg_wr_data);
            else            m_pw = int'(cfg_wr_data[15:0]);
            m_since = 0;
        end else begin
            m_since = m_since + 1;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (int'(presc_word) != m_pw) begin
                failures++;
                $display("FAIL %s prescaler word actual=%h expected=%h", phase, presc_word, m_pw);
            end
            checks++;
            if (int'(divsel_word) != m_dw) begin
                failures++;
                $display("FAIL %s divider word actual=%h expected=%h", phase, divsel_word, m_dw);
            end
            for (int i = 0; i < NCH; i++) begin
                bit exp_t;
                exp_t = ((m_since + 1) % period_of(i, m_pw, m_dw)) == 0;
                checks++;
                if (tick[i] !== exp_t) begin
                    failures++;
                    $display("FAIL %s tick[%0d] cycle %0d actual=%b expected=%b",
                             phase, i, m_since, tick[i], exp_t);
                end
            end
        end
    end

    task automatic wr(input logic sel, input logic [19:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset state and default 2-cycle ticks
        phase = "R1";
        idle(4);
        rst = 1'b0;
        idle(20);
        // R3: different prescalers per group, only low 16 bits kept (R2)
        phase = "R3";
        wr(1'b0, 20'hF0302);
        idle(60);
        // R4: a distinct select per field
        phase = "R4";
        wr(1'b1, 20'h43210);
        idle(400);
        // R8: fastest setting
        phase = "R8";
        wr(1'b0, 20'h00000);
        wr(1'b1, 20'h00000);
        idle(10);
        // R6: writes mid-period restart everything
        phase = "R6";
        wr(1'b0, 20'h0201);
        wr(1'b1, 20'h11111);
        idle(5);
        wr(1'b1, 20'h11111);
        idle(3);
        wr(1'b0, 20'h0201);
        idle(40);
        // R7: data and select move while the enable stays low
        phase = "R7";
        @(negedge clk);
        cfg_wr_sel = 1'b1; cfg_wr_data = 20'hFFFFF;
        idle(4);
        cfg_wr_sel = 1'b0;
        idle(20);
        // R2: full-width write to the divider word
        phase = "R2";
        wr(1'b1, 20'h21012);
        idle(40);
        // R5: long periods on both groups
        phase = "R5";
        wr(1'b0, 20'h0403);
        wr(1'b1, 20'h31024);
        idle(300);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        done = 1;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule